// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window through which a host processor hands commands to an embedded management controller. The host sees a 32-bit register bus with an 8-bit byte address. It fills a 16-byte outbound payload area, then writes one command word. That write marks the mailbox busy and sends a single-cycle doorbell to the controller, together with the decoded fields of the command.

The controller reads the outbound payload one 32-bit word at a time. Bytes beyond the payload size given in the command read as zero. It places any reply in a 16-byte inbound area. It finishes with a completion strobe that carries an error flag and an 8-bit error code. The host polls a status word until busy falls. It can ask for a one-cycle completion interrupt as well. It then reads the reply as words or as single bytes.

A command written while the mailbox is busy is dropped, and a sticky overrun flag records that it happened. Addresses are byte addresses. Buffer bytes are little-endian within a word: byte k of an area is bits [8*(k%4)+7 : 8*(k%4)] of word k/4.

Top module: `mbox_ipc_regs`

## Requirements
- R1: After reset the status word reads 0, and ctl_doorbell, h_irq and all decoded command outputs are 0. Reset also clears the overrun flag.
- R2: The command word is written at offset 0x00, with opcode in bits [7:0], completion-interrupt request in bit 8, sub-command in bits [15:12] and payload size in bits [23:16]. When the mailbox is idle, that write sets busy at the accepting edge. It pulses ctl_doorbell high for exactly the next cycle, and it presents the fields on ctl_opcode, ctl_ioc, ctl_sub and ctl_size.
- R3: A word read at offset 0x04 returns the status word. Bit 0 is busy, bit 1 is error, bit 2 is overrun, bits [7:4] are the sub-command, bits [15:8] are the initiator id, bits [23:16] are the error code, and bit 3 and bits [31:24] read 0.
- R4: A ctl_done strobe while busy clears busy at that edge. The same edge loads the error bit from ctl_err and the error code from ctl_err_code.
- R5: A ctl_done strobe while idle changes nothing in the status word.
- R6: A command write while busy leaves the decoded command unchanged and raises no doorbell. It sets the overrun bit, which stays set until reset.
- R7: h_irq is high for exactly the one cycle after an accepted completion, and only if the completed command had its completion-interrupt bit set.
- R8: Host word writes at 0x80+4i fill outbound word i. The controller reads word ctl_wb_idx on ctl_wb_data, where byte k reads as zero when k is not below the current command's size. A size of 16 or more exposes all bytes.
- R9: Controller writes (ctl_rb_we, ctl_rb_idx) fill inbound word i. The host reads it at 0x90+4i as a word. With h_byte set, a read at any byte address returns that byte in bits [7:0] and zero above.
- R10: Reads of the command register, of the outbound area and of unmapped offsets return 0.
- R11: h_init_id is captured at the edge that accepts a command and shown in the initiator field of the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_sel | input | 1 | Host access strobe |
| h_wr | input | 1 | Host write (1) or read (0) |
| h_byte | input | 1 | Host read returns one byte at h_addr |
| h_addr | input | 8 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_init_id | input | 8 | Initiator id captured with a command |
| h_rdata | output | 32 | Host read data (combinational) |
| h_irq | output | 1 | One-cycle completion interrupt |
| ctl_doorbell | output | 1 | One-cycle new-command pulse to controller |
| ctl_opcode | output | 8 | Decoded opcode |
| ctl_sub | output | 4 | Decoded sub-command |
| ctl_size | output | 8 | Decoded payload size in bytes |
| ctl_ioc | output | 1 | Decoded completion-interrupt request |
| ctl_wb_idx | input | 2 | Outbound word index read by controller |
| ctl_wb_data | output | 32 | Outbound word, bytes past size masked |
| ctl_rb_we | input | 1 | Controller inbound write enable |
| ctl_rb_idx | input | 2 | Inbound word index |
| ctl_rb_data | input | 32 | Inbound write data |
| ctl_done | input | 1 | Completion strobe |
| ctl_err | input | 1 | Error flag with completion |
| ctl_err_code | input | 8 | Error code with completion |

## Verification
The bench goes after the collision cases. A command that lands while busy must neither overwrite the decoded fields nor ring again; a design that accepted it would corrupt the running command and show no overrun. A completion strobe while idle must leave the latched error alone, or a stale error would vanish. Payload size is probed at a partial word (size 6) and above the buffer (size 20); an off-by-one mask would leak or hide a byte. Byte reads at odd offsets catch a wrong lane select. The interrupt is checked with the request bit both set and clear, which catches an interrupt tied to every completion.

// File: rtl/mbox_pkg.sv
// Shared types for the command mailbox: the decoded command word and
// its field positions. Assumes a 32-bit host data path.
package mbox_pkg;

    typedef struct packed {
        logic [7:0] size;
        logic [3:0] sub;
        logic       ioc;
        logic [7:0] opcode;
    } mbox_cmd_t;

    // Unpack a host command word into its fields.
    function automatic mbox_cmd_t decode_cmd(input logic [31:0] w);
        mbox_cmd_t c;
        c.size   = w[23:16];
        c.sub    = w[15:12];
        c.ioc    = w[8];
        c.opcode = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/mbox_cmd_status.sv
// Command acceptance and status state. A command write is accepted only
// when idle; one while busy sets a sticky overrun flag. Completion is
// honoured only while busy. Assumes cmd_wr and done are single-cycle
// qualified strobes from the top.
module mbox_cmd_status
    import mbox_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wr,
    input  logic [31:0]     cmd_word,
    input  logic [ID_W-1:0] init_id,
    input  logic            done,
    input  logic            done_err,
    input  logic [7:0]      done_code,
    output logic            busy,
    output logic            err,
    output logic [7:0]      err_code,
    output logic            overrun,
    output logic [ID_W-1:0] init_q,
    output mbox_cmd_t       cmd,
    output logic            doorbell,
    output logic            host_irq
);

    logic accept;
    logic finish;
    logic unused_rsvd;

    assign accept      = cmd_wr && !busy;
    assign finish      = done && busy;
    assign unused_rsvd = ^{cmd_word[31:24], cmd_word[11:9]};

    // Busy, latched command, doorbell and host interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cmd      <= '0;
            init_q   <= '0;
            doorbell <= 1'b0;
            host_irq <= 1'b0;
        end else begin
            doorbell <= accept;
            host_irq <= finish && cmd.ioc;
            if (accept) begin
                busy   <= 1'b1;
                cmd    <= decode_cmd(cmd_word);
                init_q <= init_id;
            end else if (finish) begin
                busy <= 1'b0;
            end
        end
    end

    // Error result latched by each accepted completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err      <= 1'b0;
            err_code <= 8'h00;
        end else if (finish) begin
            err      <= done_err;
            err_code <= done_code;
        end
    end

    // Sticky overrun on a command that collides with a busy mailbox.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (cmd_wr && busy) begin
            overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/mbox_wbuf.sv
// Outbound payload store. The host writes whole words; the controller
// reads one word at a time with every byte at or past the command size
// forced to zero. Assumes BUF_BYTES is a multiple of 4.
module mbox_wbuf #(
    parameter int BUF_BYTES = 16,
    localparam int WORDS = BUF_BYTES / 4,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [7:0]       size,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);

    logic [31:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Hold one outbound word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mem[g] <= wr_data;
            end
        end
    end

    // Mask bytes that lie beyond the declared payload size.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < 4; b++) begin
            if ((int'(rd_idx) * 4 + b) < int'(size)) begin
                rd_data[8*b +: 8] = mem[rd_idx][8*b +: 8];
            end
        end
    end

endmodule

// File: rtl/mbox_rbuf.sv
// Inbound reply store. The controller writes whole words; the host reads
// a word by index. Byte lane selection is left to the top.
module mbox_rbuf #(
    parameter int BUF_BYTES = 16,
    localparam int WORDS = BUF_BYTES / 4,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word
);

    logic [31:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Hold one inbound word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mem[g] <= wr_data;
            end
        end
    end

    // Host-side word read.
    assign rd_word = mem[rd_idx];

endmodule

// File: rtl/mbox_ipc_regs.sv
// Host-to-controller command mailbox top. Decodes host accesses, builds
// the status word and steers the read path. Host reads are combinational
// from h_addr; writes take effect at the clock edge of the strobe.
// Assumes one host access per cycle.
module mbox_ipc_regs
    import mbox_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter int               BUF_BYTES = 16,
    parameter logic [ADDR_W-1:0] CMD_OFF  = 'h00,
    parameter logic [ADDR_W-1:0] STAT_OFF = 'h04,
    parameter logic [ADDR_W-1:0] WB_BASE  = 'h80,
    parameter logic [ADDR_W-1:0] RB_BASE  = 'h90,
    localparam int BUF_AW = $clog2(BUF_BYTES),
    localparam int IDX_W  = $clog2(BUF_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_sel,
    input  logic              h_wr,
    input  logic              h_byte,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [31:0]       h_wdata,
    input  logic [7:0]        h_init_id,
    output logic [31:0]       h_rdata,
    output logic              h_irq,
    output logic              ctl_doorbell,
    output logic [7:0]        ctl_opcode,
    output logic [3:0]        ctl_sub,
    output logic [7:0]        ctl_size,
    output logic              ctl_ioc,
    input  logic [IDX_W-1:0]  ctl_wb_idx,
    output logic [31:0]       ctl_wb_data,
    input  logic              ctl_rb_we,
    input  logic [IDX_W-1:0]  ctl_rb_idx,
    input  logic [31:0]       ctl_rb_data,
    input  logic              ctl_done,
    input  logic              ctl_err,
    input  logic [7:0]        ctl_err_code
);

    logic        wr_hit, rd_hit;
    logic        cmd_wr, wb_wr;
    logic        stat_hit, rb_hit;
    logic        busy_q, err_q, overrun_q;
    logic [7:0]  err_code_q, init_q;
    mbox_cmd_t   cmd_q;
    logic [31:0] status_w, rb_word, rd_word;
    logic [IDX_W-1:0] buf_idx;

    assign wr_hit  = h_sel && h_wr;
    assign rd_hit  = h_sel && !h_wr;
    assign buf_idx = h_addr[BUF_AW-1:2];

    // Address decode for writes and reads.
    always_comb begin
        cmd_wr   = wr_hit && (h_addr == CMD_OFF);
        wb_wr    = wr_hit && (h_addr[ADDR_W-1:BUF_AW] == WB_BASE[ADDR_W-1:BUF_AW]);
        stat_hit = (h_addr[ADDR_W-1:2] == STAT_OFF[ADDR_W-1:2]);
        rb_hit   = (h_addr[ADDR_W-1:BUF_AW] == RB_BASE[ADDR_W-1:BUF_AW]);
    end

    mbox_cmd_status #(.ID_W(8)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_word  (h_wdata),
        .init_id   (h_init_id),
        .done      (ctl_done),
        .done_err  (ctl_err),
        .done_code (ctl_err_code),
        .busy      (busy_q),
        .err       (err_q),
        .err_code  (err_code_q),
        .overrun   (overrun_q),
        .init_q    (init_q),
        .cmd       (cmd_q),
        .doorbell  (ctl_doorbell),
        .host_irq  (h_irq)
    );

    mbox_wbuf #(.BUF_BYTES(BUF_BYTES)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wb_wr),
        .wr_idx  (buf_idx),
        .wr_data (h_wdata),
        .size    (cmd_q.size),
        .rd_idx  (ctl_wb_idx),
        .rd_data (ctl_wb_data)
    );

    mbox_rbuf #(.BUF_BYTES(BUF_BYTES)) u_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_rb_we),
        .wr_idx  (ctl_rb_idx),
        .wr_data (ctl_rb_data),
        .rd_idx  (buf_idx),
        .rd_word (rb_word)
    );

    assign ctl_opcode = cmd_q.opcode;
    assign ctl_sub    = cmd_q.sub;
    assign ctl_size   = cmd_q.size;
    assign ctl_ioc    = cmd_q.ioc;

    // Assemble the host-visible status word.
    assign status_w = {8'h00, err_code_q, init_q, cmd_q.sub,
                       1'b0, overrun_q, err_q, busy_q};

    // Select the word addressed by the host; write-only and unmapped read 0.
    always_comb begin
        if (stat_hit)    rd_word = status_w;
        else if (rb_hit) rd_word = rb_word;
        else             rd_word = '0;
    end

    // Drive read data as a full word or a single byte lane.
    always_comb begin
        if (!rd_hit)     h_rdata = '0;
        else if (h_byte) h_rdata = {24'h0, 8'(rd_word >> {h_addr[1:0], 3'b000})};
        else             h_rdata = rd_word;
    end

endmodule

// File: rtl/mbox_ipc_regs_chk.sv
// Protocol checker for the mailbox, attached to every instance of the top
// by the bind at the end of this file.
module mbox_ipc_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic       busy,
    input logic       doorbell,
    input logic       done,
    input logic       ioc,
    input logic       irq,
    input logic       overrun,
    input logic [7:0] opcode
);

    assert_accept_rings_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (doorbell && busy));

    assert_doorbell_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell);

    assert_done_clears_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy && !cmd_wr) |=> !busy);

    assert_idle_done_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !busy && !cmd_wr) |=> !busy);

    assert_busy_cmd_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> ($stable(opcode) && !doorbell && overrun));

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(done && busy && ioc));

endmodule

bind mbox_ipc_regs mbox_ipc_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .busy     (busy_q),
    .doorbell (ctl_doorbell),
    .done     (ctl_done),
    .ioc      (cmd_q.ioc),
    .irq      (h_irq),
    .overrun  (overrun_q),
    .opcode   (cmd_q.opcode)
);

// File: tb/mbox_ipc_regs_tb.sv
module mbox_ipc_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 32;

    // Vector: {op[3:0], addr[7:0], data[31:0], exp[31:0], req[3:0]}
    // op 0 host write, 1 host word read, 2 host byte read,
    // 3 ctl inbound write, 4 ctl outbound read, 5 ctl done (data[8]=err, data[7:0]=code)
    localparam logic [79:0] VEC [NVEC] = '{
        {4'd0, 8'h80, 32'h44332211, 32'h0, 4'd8},        // R8 fill
        {4'd0, 8'h84, 32'h88776655, 32'h0, 4'd8},
        {4'd0, 8'h88, 32'hCCBBAA99, 32'h0, 4'd8},
        {4'd0, 8'h8C, 32'h00FFEEDD, 32'h0, 4'd8},
        {4'd1, 8'h80, 32'h0, 32'h00000000, 4'd10},       // R10 outbound reads 0
        {4'd1, 8'h00, 32'h0, 32'h00000000, 4'd10},       // R10 command reads 0
        {4'd1, 8'h40, 32'h0, 32'h00000000, 4'd10},       // R10 unmapped
        {4'd0, 8'h00, 32'h000630FF, 32'h0, 4'd2},        // R2 cmd size 6 sub 3
        {4'd1, 8'h04, 32'h0, 32'h00005A31, 4'd3},        // R3 R11 status layout
        {4'd4, 8'h00, 32'h0, 32'h44332211, 4'd8},        // R8 full word
        {4'd4, 8'h01, 32'h0, 32'h00006655, 4'd8},        // R8 partial word
        {4'd4, 8'h02, 32'h0, 32'h00000000, 4'd8},
        {4'd4, 8'h03, 32'h0, 32'h00000000, 4'd8},
        {4'd3, 8'h00, 32'hDDCCBBAA, 32'h0, 4'd9},        // R9 reply fill
        {4'd3, 8'h02, 32'h13579BDF, 32'h0, 4'd9},
        {4'd5, 8'h00, 32'h0000017E, 32'h0, 4'd4},        // R4 done with error
        {4'd1, 8'h04, 32'h0, 32'h007E5A32, 4'd4},
        {4'd1, 8'h90, 32'h0, 32'hDDCCBBAA, 4'd9},        // R9 word reads
        {4'd1, 8'h98, 32'h0, 32'h13579BDF, 4'd9},
        {4'd2, 8'h93, 32'h0, 32'h000000DD, 4'd9},        // R9 byte reads
        {4'd2, 8'h99, 32'h0, 32'h0000009B, 4'd9},
        {4'd2, 8'h91, 32'h0, 32'h000000BB, 4'd9},
        {4'd5, 8'h00, 32'h00000011, 32'h0, 4'd5},        // R5 idle done
        {4'd1, 8'h04, 32'h0, 32'h007E5A32, 4'd5},
        {4'd0, 8'h00, 32'h0014A101, 32'h0, 4'd2},        // R2 size 20 sub A ioc
        {4'd1, 8'h04, 32'h0, 32'h007E5AA3, 4'd3},
        {4'd4, 8'h03, 32'h0, 32'h00FFEEDD, 4'd8},        // R8 size over buffer
        {4'd0, 8'h00, 32'h000000F4, 32'h0, 4'd6},        // R6 collision
        {4'd1, 8'h04, 32'h0, 32'h007E5AA7, 4'd6},
        {4'd5, 8'h00, 32'h00000000, 32'h0, 4'd4},
        {4'd1, 8'h04, 32'h0, 32'h00005AA4, 4'd6},        // R6 sticky
        {4'd2, 8'h05, 32'h0, 32'h0000005A, 4'd11}        // R11 initiator byte
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        h_sel, h_wr, h_byte;
    logic [7:0]  h_addr;
    logic [31:0] h_wdata;
    logic [7:0]  h_init_id;
    logic [31:0] h_rdata;
    logic        h_irq, ctl_doorbell, ctl_ioc;
    logic [7:0]  ctl_opcode, ctl_size;
    logic [3:0]  ctl_sub;
    logic [1:0]  ctl_wb_idx, ctl_rb_idx;
    logic [31:0] ctl_wb_data, ctl_rb_data;
    logic        ctl_rb_we, ctl_done, ctl_err;
    logic [7:0]  ctl_err_code;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbox_ipc_regs u_dut (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_byte(h_byte),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_init_id(h_init_id),
        .h_rdata(h_rdata), .h_irq(h_irq), .ctl_doorbell(ctl_doorbell),
        .ctl_opcode(ctl_opcode), .ctl_sub(ctl_sub), .ctl_size(ctl_size),
        .ctl_ioc(ctl_ioc), .ctl_wb_idx(ctl_wb_idx), .ctl_wb_data(ctl_wb_data),
        .ctl_rb_we(ctl_rb_we), .ctl_rb_idx(ctl_rb_idx), .ctl_rb_data(ctl_rb_data),
        .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_err_code(ctl_err_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        h_sel = 1'b1; h_wr = 1'b1; h_addr = a; h_wdata = d; h_byte = 1'b0;
        @(negedge clk);
        h_sel = 1'b0; h_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, input logic b, output logic [31:0] v);
        @(negedge clk);
        h_sel = 1'b1; h_wr = 1'b0; h_addr = a; h_byte = b;
        #1 v = h_rdata;
        h_sel = 1'b0; h_byte = 1'b0;
    endtask

    task automatic ctl_finish(input logic e, input logic [7:0] code);
        @(negedge clk);
        ctl_done = 1'b1; ctl_err = e; ctl_err_code = code;
        @(negedge clk);
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = 8'h00;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        h_sel = 0; h_wr = 0; h_byte = 0; h_addr = 0; h_wdata = 0; h_init_id = 8'h5A;
        ctl_wb_idx = 0; ctl_rb_we = 0; ctl_rb_idx = 0; ctl_rb_data = 0;
        ctl_done = 0; ctl_err = 0; ctl_err_code = 0;
        rst_n = 1'b0;
        apply_reset();

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0]  op;
            logic [7:0]  a;
            logic [31:0] d, e;
            string       rq;
            {op, a, d, e} = VEC[i][79:4];
            rq = $sformatf("R%0d", VEC[i][3:0]);
            case (op)
                4'd0: host_write(a, d);
                4'd1: begin host_read(a, 1'b0, v); check(rq, v, e); end
                4'd2: begin host_read(a, 1'b1, v); check(rq, v, e); end
                4'd3: begin
                    @(negedge clk);
                    ctl_rb_we = 1'b1; ctl_rb_idx = a[1:0]; ctl_rb_data = d;
                    @(negedge clk);
                    ctl_rb_we = 1'b0;
                end
                4'd4: begin
                    @(negedge clk);
                    ctl_wb_idx = a[1:0];
                    #1 check(rq, ctl_wb_data, e);
                end
                default: ctl_finish(d[8], d[7:0]);
            endcase
        end

        // R1: reset state, including overrun cleared
        apply_reset();
        host_read(8'h04, 1'b0, v);
        check("R1 status", v, 32'h0);
        check("R1 doorbell", {31'h0, ctl_doorbell}, 32'h0);
        check("R1 irq", {31'h0, h_irq}, 32'h0);
        check("R1 opcode", {24'h0, ctl_opcode}, 32'h0);

        // R2: doorbell pulse and decoded fields; R11 new initiator
        h_init_id = 8'h21;
        host_write(8'h00, 32'h00085123);
        check("R2 doorbell", {31'h0, ctl_doorbell}, 32'h1);
        check("R2 fields", {11'h0, ctl_size, ctl_sub, ctl_ioc, ctl_opcode},
              {11'h0, 8'h08, 4'h5, 1'b1, 8'h23});
        @(negedge clk);
        check("R2 doorbell single", {31'h0, ctl_doorbell}, 32'h0);
        host_read(8'h05, 1'b1, v);
        check("R11 initiator", v, 32'h21);

        // R6: command while busy is dropped
        host_write(8'h00, 32'h000000AA);
        check("R6 no doorbell", {31'h0, ctl_doorbell}, 32'h0);
        check("R6 opcode kept", {24'h0, ctl_opcode}, 32'h23);

        // R7: interrupt requested
        ctl_finish(1'b0, 8'h00);
        check("R7 irq high", {31'h0, h_irq}, 32'h1);
        @(negedge clk);
        check("R7 irq single", {31'h0, h_irq}, 32'h0);

        // R7: interrupt not requested
        host_write(8'h00, 32'h00002077);
        ctl_finish(1'b0, 8'h00);
        check("R7 irq absent", {31'h0, h_irq}, 32'h0);
        host_read(8'h04, 1'b0, v);
        check("R4 idle after done", v, 32'h00002124);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule